// File: doc/BRIEF.md
# Soft Mute Ramp for a Stereo Sample Stream

This block sits in the digital path of a stereo audio output and fades both channels to silence and back without an audible step. Every sample frame arrives with a one-cycle strobe carrying a 24-bit two's-complement left and right sample. A single gain value is applied to both channels. That gain is a linear counter between zero and unity, and it moves one step per frame in the direction that the mute request selects.

The mute request is level-sensitive. While it is high at a frame strobe, the gain steps down. While it is low, the gain steps up. When the request changes in the middle of a ramp, the gain reverses from the value it has reached at the same rate. A speed-mode input sets the step size, so a full ramp lasts 1024 frames at the base rate, 2048 frames at double rate and 4096 frames at quad rate. These durations are the same in wall-clock time for a stream running at that rate.

Each scaled sample is registered and leaves the block one cycle after its strobe, together with a valid strobe and a flag that reports full silence.

Top module: `smute_ramp`

## Requirements
- R1: After reset the gain is unity (4096 of 4096), `out_valid` is 0, both output samples are 0 and `muted` is 0.
- R2: `out_valid` is high for exactly the one cycle that follows each cycle with `in_valid` high, and is low in every other cycle. The samples presented with it are scaled by the gain held before that frame's step.
- R3: At unity gain each output sample equals its input sample bit for bit, including 24'h7FFFFF and 24'h800000.
- R4: With `speed_mode` = 0 (normal), each frame with `mute_req` high lowers the gain by 4 of 4096, so that 1024 such frames reach zero from unity.
- R5: With `speed_mode` = 1 (double) the step is 2 and a full ramp takes 2048 frames. With `speed_mode` = 2 or 3 (quad) the step is 1 and a full ramp takes 4096 frames.
- R6: Each frame with `mute_req` low raises the gain by the same step, saturating at unity and never passing it.
- R7: A change of `mute_req` during a ramp reverses the direction from the current gain on the next frame, with no jump.
- R8: Each output sample is input × gain / 4096, truncated toward zero, with the same gain on both channels.
- R9: While the gain is zero, both output samples are exactly 0 whatever the input.
- R10: `mute_req` is looked at only in cycles with `in_valid` high. Its value in the other cycles has no effect on the gain.
- R11: `muted` is high exactly when the gain is zero. It takes its new value in the same cycle as `out_valid` for the frame that caused the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | One-cycle strobe marking a stereo frame |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| mute_req | input | 1 | Mute request, level-sensitive, sampled at the strobe |
| speed_mode | input | 2 | 0 normal, 1 double, 2 or 3 quad |
| out_valid | output | 1 | Strobe for the scaled frame |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |
| muted | output | 1 | High while the gain is zero |

## Verification
The properties assume that `in_valid` is a single-cycle pulse, so every frame yields exactly one output strobe. They also assume that the gain moves by at most the largest step (4) between strobes. To keep within this, the stimulus always puts at least one idle cycle between frames. It changes `speed_mode` and `mute_req` only at frame boundaries, except in the one sequence where `mute_req` is deliberately pulsed in the idle cycles to show that such pulses are not seen. Because every frame is followed by an idle cycle, the checks that outputs hold still between strobes and that no strobe appears without a frame are exercised throughout the run.

// File: rtl/smute_pkg.sv
package smute_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_QUAD_B = 2'd3
    } spd_e;

    // Ratio of the quad-rate ramp length to the normal-rate ramp length
    localparam int unsigned RATE_SPAN = 4;

    // Gain step per frame for each speed mode
    function automatic int unsigned step_of(input spd_e mode);
        unique case (mode)
            SPD_NORMAL: step_of = 4;
            SPD_DOUBLE: step_of = 2;
            default:    step_of = 1;
        endcase
    endfunction

endpackage

// File: rtl/smute_gain_ctrl.sv
module smute_gain_ctrl
    import smute_pkg::*;
#(
    parameter int unsigned GAIN_W   = 13,
    parameter int unsigned GAIN_MAX = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic              mute_req,
    input  logic [1:0]        speed_mode,
    output logic [GAIN_W-1:0] gain,
    output logic              gain_zero
);

    localparam logic [GAIN_W-1:0] GMAX = GAIN_W'(GAIN_MAX);

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic              zero;
    } ctrl_t;

    ctrl_t             st_d, st_q;
    logic [GAIN_W-1:0] step;
    spd_e              mode;

    always_comb begin
        mode = spd_e'(speed_mode);
        step = GAIN_W'(step_of(mode));
        st_d = st_q;
        if (frame_stb) begin
            if (mute_req) begin
                // falling: clamp at silence
                st_d.gain = (st_q.gain > step) ? (st_q.gain - step) : '0;
            end else begin
                // rising: clamp at unity
                st_d.gain = (st_q.gain >= (GMAX - step)) ? GMAX : (st_q.gain + step);
            end
        end
        st_d.zero = (st_d.gain == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gain <= GMAX;
            st_q.zero <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain      = st_q.gain;
    assign gain_zero = st_q.zero;

endmodule

// File: rtl/smute_scale.sv
module smute_scale #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned GAIN_W = 13,
    parameter int unsigned FRAC_W = 12
) (
    input  logic [DATA_W-1:0] sample,
    input  logic [GAIN_W-1:0] gain,
    output logic [DATA_W-1:0] scaled
);

    localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] RND = PROD_W'((64'd1 << FRAC_W) - 64'd1);

    logic signed [PROD_W-1:0] s_ext, g_ext, prod, biased;
    logic                     unused_bits;

    always_comb begin
        s_ext  = {{(GAIN_W + 1){sample[DATA_W-1]}}, sample};
        g_ext  = {{(DATA_W + 1){1'b0}}, gain};
        prod   = s_ext * g_ext;
        // negative products get a bias so the shift truncates toward zero
        biased = prod[PROD_W-1] ? (prod + RND) : prod;
        scaled = biased[FRAC_W +: DATA_W];
    end

    assign unused_bits = ^{biased[PROD_W-1:FRAC_W+DATA_W], biased[FRAC_W-1:0]};

endmodule

// File: rtl/smute_ramp.sv
module smute_ramp
    import smute_pkg::*;
#(
    parameter int unsigned DATA_W      = 24,
    parameter int unsigned BASE_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              mute_req,
    input  logic [1:0]        speed_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              muted
);

    localparam int unsigned GAIN_MAX = BASE_FRAMES * RATE_SPAN;
    localparam int unsigned FRAC_W   = $clog2(GAIN_MAX);
    localparam int unsigned GAIN_W   = FRAC_W + 1;
    localparam int unsigned N_CH     = 2;

    typedef struct packed {
        logic                         valid;
        logic [N_CH-1:0][DATA_W-1:0] ch;
    } out_t;

    out_t                        out_d, out_q;
    logic [GAIN_W-1:0]           gain_w;
    logic                        zero_w;
    logic [N_CH-1:0][DATA_W-1:0] samp_in, samp_sc;

    assign samp_in[0] = in_left;
    assign samp_in[1] = in_right;

    smute_gain_ctrl #(
        .GAIN_W   (GAIN_W),
        .GAIN_MAX (GAIN_MAX)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (in_valid),
        .mute_req   (mute_req),
        .speed_mode (speed_mode),
        .gain       (gain_w),
        .gain_zero  (zero_w)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        smute_scale #(
            .DATA_W (DATA_W),
            .GAIN_W (GAIN_W),
            .FRAC_W (FRAC_W)
        ) u_scale (
            .sample (samp_in[c]),
            .gain   (gain_w),
            .scaled (samp_sc[c])
        );
    end

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.ch = samp_sc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_left  = out_q.ch[0];
    assign out_right = out_q.ch[1];
    assign muted     = zero_w;

endmodule

// File: rtl/smute_chk.sv
module smute_chk #(
    parameter int unsigned DATA_W   = 24,
    parameter int unsigned GAIN_W   = 13,
    parameter int unsigned GAIN_MAX = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_left,
    input logic [DATA_W-1:0] in_right,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              muted,
    input logic [GAIN_W-1:0] gain
);

    localparam logic [GAIN_W:0] GMAX = (GAIN_W+1)'(GAIN_MAX);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ({1'b0, gain} == GMAX)) |=> (out_left == $past(in_left)) && (out_right == $past(in_right))); // R3
    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) {1'b0, gain} <= GMAX); // R6
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((($past(gain) >= gain) ? ($past(gain) - gain) : (gain - $past(gain))) <= GAIN_W'(4))); // R7
    AST_SILENT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && muted) |=> (out_left == '0) && (out_right == '0)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(gain)); // R10
    AST_MUTED_FLAG: assert property (@(posedge clk) disable iff (!rst_n) muted == (gain == '0)); // R11

endmodule

bind smute_ramp smute_chk #(
    .DATA_W   (DATA_W),
    .GAIN_W   (GAIN_W),
    .GAIN_MAX (GAIN_MAX)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .muted     (muted),
    .gain      (gain_w)
);

// File: tb/test_smute_ramp.sv
`timescale 1ns/1ps
module test_smute_ramp;

    localparam int GMAX = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_left = '0, in_right = '0;
    logic        mute_req = 1'b0;
    logic [1:0]  speed_mode = 2'd0;
    logic        out_valid, muted;
    logic [23:0] out_left, out_right;

    always #2 clk = ~clk;   // 250 MHz

    smute_ramp i_smute_ramp (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .mute_req(mute_req), .speed_mode(speed_mode),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right), .muted(muted)
    );

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        logic        m;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_fail = 0;
    int          g_model = GMAX;
    string       cur_tag = "R3";
    logic [31:0] lcg = 32'h1234_5678;
    bit          done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
        end
    endtask

    function automatic logic [23:0] scale(input logic [23:0] s, input int g);
        longint p;
        p = longint'($signed(s)) * longint'(g);
        return 24'(p / GMAX);   // integer division truncates toward zero
    endfunction

    function automatic int step_now();
        return (speed_mode == 2'd0) ? 4 : (speed_mode == 2'd1) ? 2 : 1;
    endfunction

    // driver: one frame followed by one idle cycle
    task automatic frame(input logic m, input logic [23:0] l, input logic [23:0] r, input bit glitch);
        exp_t e;
        @(negedge clk);
        mute_req = m; in_left = l; in_right = r; in_valid = 1'b1;
        e.l = scale(l, g_model);
        e.r = scale(r, g_model);
        if (m) g_model = (g_model > step_now()) ? g_model - step_now() : 0;
        else   g_model = (g_model + step_now() >= GMAX) ? GMAX : g_model + step_now();
        e.m = (g_model == 0);
        e.tag = cur_tag;
        sb.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        if (glitch) mute_req = ~m;
    endtask

    task automatic run(input logic m, input int n);
        for (int i = 0; i < n; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            frame(m, lcg[31:8], lcg[23:0] ^ 24'h5A5A5A, 1'b0);
        end
    endtask

    // monitor: pops one expected item per output strobe
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(out_left == e.l, e.tag, out_left, e.l);
                check(out_right == e.r, e.tag, out_right, e.r);
                check(muted == e.m, "R11", muted, e.m);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_left == 24'd0 && out_right == 24'd0, "R1", out_left, 0);
        check(muted == 1'b0, "R1", muted, 0);

        cur_tag = "R3";
        frame(1'b0, 24'h7FFFFF, 24'h800000, 1'b0);
        frame(1'b0, 24'h000000, 24'hFFFFFF, 1'b0);
        frame(1'b0, 24'h123456, 24'hABCDEF, 1'b0);
        run(1'b0, 3);

        cur_tag = "R4"; speed_mode = 2'd0;
        run(1'b1, 1024);
        @(negedge clk);
        check(muted == 1'b1, "R4", muted, 1);

        cur_tag = "R9";
        frame(1'b1, 24'h7FFFFF, 24'h800000, 1'b0);
        run(1'b1, 7);

        cur_tag = "R6";
        run(1'b0, 1030);

        cur_tag = "R5"; speed_mode = 2'd1;
        run(1'b1, 2047);
        @(negedge clk);
        check(muted == 1'b0, "R5", muted, 0);
        run(1'b1, 1);
        @(negedge clk);
        check(muted == 1'b1, "R5", muted, 1);
        cur_tag = "R6";
        run(1'b0, 2050);

        cur_tag = "R5"; speed_mode = 2'd3;
        run(1'b1, 4096);
        @(negedge clk);
        check(muted == 1'b1, "R5", muted, 1);
        speed_mode = 2'd2;
        cur_tag = "R6";
        run(1'b0, 4100);

        cur_tag = "R7"; speed_mode = 2'd0;
        run(1'b1, 300);
        run(1'b0, 200);
        run(1'b1, 400);
        run(1'b0, 600);

        cur_tag = "R8"; speed_mode = 2'd2;
        frame(1'b1, 24'h800000, 24'h7FFFFF, 1'b0);
        frame(1'b1, 24'hFFFFFF, 24'h000001, 1'b0);
        frame(1'b1, 24'hFFF001, 24'h000FFF, 1'b0);
        speed_mode = 2'd0;
        run(1'b1, 40);
        frame(1'b1, 24'h876543, 24'h789ABC, 1'b0);
        run(1'b0, 60);

        cur_tag = "R10";
        for (int i = 0; i < 20; i++) frame(1'b0, 24'(i * 77777), 24'(~(i * 4321)), 1'b1);
        mute_req = 1'b0;

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", sb.size(), 0);
        check(out_valid == 1'b0, "R2", out_valid, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule